// File: doc/BRIEF.md
# Banked Binary Point Register for Group 1 Priorities

This block stores the 3-bit binary point that tells the interrupt logic how to split an 8-bit priority into a group part and a subpriority part. Only the group part decides preemption. The block drives that split as an 8-bit mask. A priority ANDed with the mask gives the preemption key.

The register sits next to a separate Group 0 binary point register, which is outside this block. The value of that companion register comes in as an input. A common-binary-point control can make this register an alias of the companion, and the effect of the alias depends on the security state of the access:
- Non-secure reads see the companion value incremented, stopping at 7. Non-secure writes are discarded.
- Secure reads see the companion value as it is. Secure writes are passed out to the companion register.

Outside alias mode, a written value below the reset floor is raised to the floor. The floor is one more than the lowest legal companion value.

Top module: `bpr_bank`

## Requirements
- R1: After reset the stored binary point equals G0_MIN+1 (1 by default), and a read outside alias mode returns that value.
- R2: Read data bits [63:3] are always zero.
- R3: Outside alias mode, a write of a value at or above the floor is returned by reads from the next cycle on. A read in the write cycle returns the old value.
- R4: Outside alias mode, a write of a value below the floor (including 0) stores the floor instead.
- R5: The mask output has ones on bits [7:N] and zeros on bits [N-1:0], where N is the effective binary point.
- R6: In alias mode, a non-secure read returns the companion value plus one, saturated at 7.
- R7: In alias mode, a non-secure write changes neither the stored value nor the companion. The companion write strobe stays low.
- R8: In alias mode, a secure read returns the companion value unchanged.
- R9: In alias mode, a secure write raises the companion write strobe for one cycle with bits [2:0] of the write data, and leaves the stored value unchanged.
- R10: In alias mode the effective binary point for the mask is the companion value plus one, saturated at 7. Outside alias mode it is the stored value.
- R11: Write data bits [63:3] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_secure | input | 1 | Access is from the secure state |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read view for the current security state |
| cbp_en | input | 1 | Common binary point (alias) mode |
| g0_bp | input | 3 | Companion Group 0 binary point |
| g0_wr_en | output | 1 | Redirected write strobe to companion |
| g0_wr_data | output | 3 | Redirected write value |
| grp_mask | output | 8 | Group priority mask |

## Verification
Two events can land in the same cycle: a write, and a change of the alias control or of the companion value. The bench covers three such cases:
- Alias mode turns on in the very cycle a write arrives. The write must then follow the alias rules and must not update the stored field.
- A write arrives while the read port is being sampled. The read must show the old value until the next edge.
- The companion changes while a write is redirected to it.

A behavioural model that is updated at every edge judges each of these cycles against all outputs.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
   localparam int BP_W   = 3;
   localparam int PRIO_W = 8;
   localparam int REG_W  = 64;
   typedef logic [BP_W-1:0] bp_t;

   function automatic bp_t bp_sat_inc(input bp_t v);
      return (v == {BP_W{1'b1}}) ? v : bp_t'(v + 1'b1);
   endfunction
endpackage

// File: rtl/bp_clamp.sv
module bp_clamp #(
   parameter int BP_W  = 3,
   parameter int FLOOR = 1
) (
   input  logic [BP_W-1:0] raw,
   output logic [BP_W-1:0] clamped
);
   localparam logic [BP_W-1:0] FLOOR_V = BP_W'(FLOOR);
   always_comb clamped = (raw < FLOOR_V) ? FLOOR_V : raw;
endmodule

// File: rtl/bp_view.sv
module bp_view
   import bpr_pkg::*;
(
   input  bp_t  stored,
   input  bp_t  g0_val,
   input  logic alias_on,
   input  logic secure,
   output bp_t  view,
   output bp_t  eff
);
   bp_t g0_inc;
   always_comb begin
      g0_inc = bp_sat_inc(g0_val);
      if (!alias_on)   view = stored;
      else if (secure) view = g0_val;
      else             view = g0_inc;
      eff = alias_on ? g0_inc : stored;
   end
endmodule

// File: rtl/bp_mask_gen.sv
module bp_mask_gen #(
   parameter int BP_W   = 3,
   parameter int PRIO_W = 8
) (
   input  logic [BP_W-1:0]   bp,
   output logic [PRIO_W-1:0] mask
);
   for (genvar i = 0; i < PRIO_W; i++) begin : g_bit
      localparam logic [BP_W:0] IDX = (BP_W+1)'(i);
      assign mask[i] = (IDX >= {1'b0, bp});
   end
endmodule

// File: rtl/bpr_bank.sv
module bpr_bank #(
   parameter int G0_MIN = 0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     acc_en,
   input  logic                     acc_wr,
   input  logic                     acc_secure,
   input  logic [bpr_pkg::REG_W-1:0] wr_data,
   output logic [bpr_pkg::REG_W-1:0] rd_data,
   input  logic                     cbp_en,
   input  logic [bpr_pkg::BP_W-1:0] g0_bp,
   output logic                     g0_wr_en,
   output logic [bpr_pkg::BP_W-1:0] g0_wr_data,
   output logic [bpr_pkg::PRIO_W-1:0] grp_mask
);
   import bpr_pkg::*;

   localparam int  RST_VAL = G0_MIN + 1;
   localparam bp_t RST_BP  = BP_W'(RST_VAL);

   if (G0_MIN < 0 || G0_MIN > (2**BP_W) - 2) begin : g_bad_min
      $error("G0_MIN out of range");
   end
   if (PRIO_W != 2**BP_W) begin : g_bad_prio
      $error("PRIO_W must be 2**BP_W");
   end
   if (REG_W <= BP_W) begin : g_bad_reg
      $error("REG_W too narrow");
   end

   bp_t  bp_q, wr_clamped, view, eff;
   logic own_wr;
   logic unused_hi;

   assign unused_hi = ^wr_data[REG_W-1:BP_W];
   assign own_wr    = acc_en && acc_wr && !cbp_en;

   bp_clamp #(.BP_W(BP_W), .FLOOR(RST_VAL)) u_clamp (
      .raw     (wr_data[BP_W-1:0]),
      .clamped (wr_clamped)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      bp_q <= RST_BP;
      else if (own_wr) bp_q <= wr_clamped;
   end

   bp_view u_view (
      .stored   (bp_q),
      .g0_val   (g0_bp),
      .alias_on (cbp_en),
      .secure   (acc_secure),
      .view     (view),
      .eff      (eff)
   );

   bp_mask_gen #(.BP_W(BP_W), .PRIO_W(PRIO_W)) u_mask (
      .bp   (eff),
      .mask (grp_mask)
   );

   assign rd_data    = {{(REG_W-BP_W){1'b0}}, view};
   assign g0_wr_en   = acc_en && acc_wr && cbp_en && acc_secure;
   assign g0_wr_data = wr_data[BP_W-1:0];
endmodule

// File: rtl/bpr_bank_chk.sv
module bpr_bank_chk #(
   parameter int G0_MIN = 0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        acc_en,
   input logic        acc_wr,
   input logic        acc_secure,
   input logic [2:0]  wr_lo,
   input logic [63:0] rd_data,
   input logic        cbp_en,
   input logic [2:0]  g0_bp,
   input logic        g0_wr_en,
   input logic [2:0]  g0_wr_data,
   input logic [7:0]  grp_mask
);
   localparam logic [2:0] FLOOR = 3'(G0_MIN + 1);
   logic past_ok;
   always_ff @(posedge clk) past_ok <= rst_n;

   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[63:3] == '0); // R2
   AST_FLOOR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !cbp_en |-> rd_data[2:0] >= FLOOR); // R4
   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(acc_en && acc_wr && !cbp_en) && !cbp_en) |->
      rd_data[2:0] == (($past(wr_lo) < FLOOR) ? FLOOR : $past(wr_lo))); // R3
   AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      grp_mask[7] && $onehot0(grp_mask ^ {grp_mask[6:0], 1'b0})); // R5
   AST_NS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (cbp_en && !acc_secure && g0_bp == 3'd7) |-> rd_data[2:0] == 3'd7); // R6
   AST_NS_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (cbp_en && !acc_secure && acc_en && acc_wr) |-> !g0_wr_en); // R7
   AST_S_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (cbp_en && acc_secure && acc_en && acc_wr) |-> (g0_wr_en && g0_wr_data == wr_lo)); // R9
endmodule

bind bpr_bank bpr_bank_chk #(.G0_MIN(G0_MIN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_en     (acc_en),
   .acc_wr     (acc_wr),
   .acc_secure (acc_secure),
   .wr_lo      (wr_data[2:0]),
   .rd_data    (rd_data),
   .cbp_en     (cbp_en),
   .g0_bp      (g0_bp),
   .g0_wr_en   (g0_wr_en),
   .g0_wr_data (g0_wr_data),
   .grp_mask   (grp_mask)
);

// File: tb/bpr_bank_tb.sv
module bpr_bank_tb;
   localparam int RST = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0, acc_wr = 1'b0, acc_secure = 1'b0, cbp_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic [2:0]  g0_bp = '0;
   logic [63:0] rd_data;
   logic        g0_wr_en;
   logic [2:0]  g0_wr_data;
   logic [7:0]  grp_mask;

   int tests = 0;
   int fails = 0;
   int model_bp = RST;

   always #5 clk = ~clk;

   bpr_bank u_dut (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_secure(acc_secure), .wr_data(wr_data), .rd_data(rd_data),
      .cbp_en(cbp_en), .g0_bp(g0_bp), .g0_wr_en(g0_wr_en),
      .g0_wr_data(g0_wr_data), .grp_mask(grp_mask)
   );

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // drive one cycle from a negedge, check outputs, update model at posedge
   task automatic step(input logic en, input logic wr, input logic sec,
                       input logic cbp, input logic [63:0] d,
                       input logic [2:0] g0, input string tag);
      int sat, eff, exp_rd;
      logic exp_wen;
      acc_en = en; acc_wr = wr; acc_secure = sec; cbp_en = cbp;
      wr_data = d; g0_bp = g0;
      #1;
      sat    = (g0 == 3'd7) ? 7 : int'(g0) + 1;
      exp_rd = !cbp ? model_bp : (sec ? int'(g0) : sat);
      eff    = cbp ? sat : model_bp;
      exp_wen = en && wr && cbp && sec;
      check(tag, "rd_data", rd_data, 64'(exp_rd));
      check(tag, "grp_mask", {56'd0, grp_mask}, {56'd0, 8'((9'h0FF << eff) & 9'h0FF)});
      check(tag, "g0_wr_en", {63'd0, g0_wr_en}, {63'd0, exp_wen});
      if (exp_wen) check(tag, "g0_wr_data", {61'd0, g0_wr_data}, {61'd0, d[2:0]});
      @(posedge clk);
      if (en && wr && !cbp) model_bp = (int'(d[2:0]) < RST) ? RST : int'(d[2:0]);
      @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      model_bp = RST;
      // R1 R2: reset view
      step(0, 0, 0, 0, '0, 3'd0, "R1");
      step(0, 0, 1, 0, '0, 3'd4, "R2");
      // R3 R4 R5: every write value, then idle read
      for (int v = 0; v < 8; v++) begin
         step(1, 1, v[0], 0, 64'(v), 3'd0, (v < RST) ? "R4" : "R3");
         step(0, 0, 0, 0, '0, 3'd0, "R5");
      end
      // R11: upper bits ignored
      step(1, 1, 0, 0, 64'hFFFF_FFFF_FFFF_FFF6, 3'd0, "R11");
      step(0, 0, 0, 0, '0, 3'd0, "R11");
      // R6 R8 R10: alias reads across companion values
      for (int g = 0; g < 8; g++) begin
         step(1, 0, 0, 1, '0, 3'(g), "R6");
         step(1, 0, 1, 1, '0, 3'(g), "R8");
         step(0, 0, 0, 1, '0, 3'(g), "R10");
      end
      // R7: non-secure alias write dropped, alias on in the write cycle
      step(1, 1, 0, 1, 64'd3, 3'd2, "R7");
      step(0, 0, 0, 0, '0, 3'd2, "R7");
      // R9: secure alias write redirected while companion changes
      step(1, 1, 1, 1, 64'd2, 3'd5, "R9");
      step(1, 1, 1, 1, 64'd0, 3'd2, "R9");
      step(0, 0, 0, 0, '0, 3'd0, "R9");
      // R3: read in write cycle shows old value, new one after
      step(1, 1, 0, 0, 64'd4, 3'd0, "R3");
      step(1, 1, 0, 0, 64'd0, 3'd0, "R4");
      step(0, 0, 1, 0, '0, 3'd0, "R4");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule